// File: doc/BRIEF.md
# Crystal Oscillator Amplitude Step Controller

This block closes a crystal-oscillator amplitude loop digitally instead of with an analog loop amplifier. An external converter turns the measured peak-to-peak swing into a code and presents it with a one-cycle strobe. The controller compares that code with a target and a programmable tolerance, then moves the oscillator's amplifier bias code by one step up or down, or leaves it unchanged. An external current DAC turns the bias code into a current.

Correction runs only while a window is open. The window opens in three cases: after reset, for start-up, until the loop first settles; at any time when continuous mode is selected; and while the system raises a quiet-window input. When the window is closed the bias code is frozen, so the loop adds no control activity. The bias starts at full scale so that the crystal is sure to start. It never wraps at either end, and it reports when it sits at a limit. A settled output shows that a programmed number of consecutive samples in a row fell inside the tolerance band.

Top module: `xo_amp_regulator`

## Requirements
- R1: While reset is held and after it is released, bias_code is all ones, at_ceiling is 1, at_floor is 0 and settled is 0.
- R2: An accepted sample with sample_code > target_code + band_lsb lowers bias_code by exactly 1. The new value is visible after the third rising edge counted from the edge that accepted the strobe.
- R3: An accepted sample with sample_code + band_lsb < target_code raises bias_code by exactly 1, with the same latency as R2.
- R4: An accepted sample inside the inclusive band [target_code - band_lsb, target_code + band_lsb] leaves bias_code unchanged.
- R5: bias_code never wraps. A step down at 0 and a step up at all ones leave it unchanged. at_floor is 1 exactly when bias_code is 0, and at_ceiling is 1 exactly when bias_code is all ones.
- R6: settled is 1 when the count of consecutive in-band accepted samples is at least settle_len. Any out-of-band accepted sample clears the count. The count saturates at its maximum.
- R7: After reset, samples are acted on with run_cont = 0 and quiet_win = 0 until settled first becomes 1. From then until the next reset, this start-up window stays closed.
- R8: With the start-up window closed and run_cont = 0, samples strobed while quiet_win = 0 are ignored, and bias_code and settled keep their values. Samples strobed while quiet_win = 1 are acted on.
- R9: With run_cont = 1, every accepted sample is acted on, whatever quiet_win is.
- R10: A strobe is accepted only while the controller waits for a sample. A strobe held high for two cycles gives a single step, and bias_code changes only in the cycle after a step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_cont | input | 1 | 1 = correct on every sample |
| quiet_win | input | 1 | External window in which correction is allowed |
| sample_vld | input | 1 | One-cycle strobe: sample_code holds a new result |
| sample_code | input | AMP_W (8) | Measured peak-to-peak amplitude code |
| target_code | input | AMP_W (8) | Desired amplitude code |
| band_lsb | input | AMP_W (8) | Half-width of the tolerance band, in LSBs |
| settle_len | input | CNT_W (4) | Consecutive in-band samples needed for settled |
| bias_code | output | BIAS_W (6) | Amplifier bias code sent to the current DAC |
| at_floor | output | 1 | bias_code is 0 |
| at_ceiling | output | 1 | bias_code is full scale |
| settled | output | 1 | Loop has stayed inside the band long enough |

## Verification
The step decision is driven with codes exactly at both edges of the band and just outside them. This separates an inclusive band from an exclusive one and an up step from a down step. Runs of far-out samples drive the bias into both ends, which exposes wrap-around and wrong limit flags. Samples are also strobed with the window open and closed, and with the start-up window still open and after it has closed. This shows whether gating comes from the right source. Constrained random samples near a moving target, mixed with random mode and window settings, are checked against a reference model of the bias and the settle count.

// File: rtl/xo_amp_pkg.sv
package xo_amp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_DECIDE = 3'd2,
    ST_APPLY  = 3'd3,
    ST_HOLD   = 3'd4
  } ctl_state_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/amp_band_cmp.sv
module amp_band_cmp
  import xo_amp_pkg::*;
#(
  parameter int AMP_W = 8
) (
  input  logic [AMP_W-1:0] meas,
  input  logic [AMP_W-1:0] goal,
  input  logic [AMP_W-1:0] half_band,
  output step_e            dir
);
  localparam int SUM_W = AMP_W + 1;

  logic [SUM_W-1:0] meas_hi;
  logic [SUM_W-1:0] goal_hi;

  // widened sums so band edges never overflow
  always_comb begin
    meas_hi = {1'b0, meas} + {1'b0, half_band};
    goal_hi = {1'b0, goal} + {1'b0, half_band};
    if (meas_hi < {1'b0, goal})
      dir = STEP_UP;           // swing too small: more bias
    else if ({1'b0, meas} > goal_hi)
      dir = STEP_DN;           // swing too large: less bias
    else
      dir = STEP_NONE;
  end
endmodule

// File: rtl/bias_stepper.sv
module bias_stepper
  import xo_amp_pkg::*;
#(
  parameter int BIAS_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  step_e             dir,
  output logic [BIAS_W-1:0] bias,
  output logic              floor_hit,
  output logic              ceil_hit
);
  localparam logic [BIAS_W-1:0] FULL = {BIAS_W{1'b1}};

  logic [BIAS_W-1:0] bias_q, bias_d;

  always_comb begin
    bias_d = bias_q;
    if (step_en) begin
      case (dir)
        STEP_UP: if (bias_q != FULL) bias_d = bias_q + 1'b1;
        STEP_DN: if (bias_q != '0)   bias_d = bias_q - 1'b1;
        default: bias_d = bias_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bias_q <= FULL;
    else if (step_en) bias_q <= bias_d;
  end

  assign bias      = bias_q;
  assign floor_hit = (bias_q == '0);
  assign ceil_hit  = (bias_q == FULL);
endmodule

// File: rtl/settle_tracker.sv
module settle_tracker #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic             in_band,
  input  logic [CNT_W-1:0] need,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (upd_en) begin
      if (!in_band)              run_d = '0;
      else if (run_q != CNT_MAX) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (upd_en) run_q <= run_d;
  end

  assign done = (run_q >= need);
endmodule

// File: rtl/xo_amp_regulator.sv
module xo_amp_regulator
  import xo_amp_pkg::*;
#(
  parameter int AMP_W  = 8,
  parameter int BIAS_W = 6,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_cont,
  input  logic              quiet_win,
  input  logic              sample_vld,
  input  logic [AMP_W-1:0]  sample_code,
  input  logic [AMP_W-1:0]  target_code,
  input  logic [AMP_W-1:0]  band_lsb,
  input  logic [CNT_W-1:0]  settle_len,
  output logic [BIAS_W-1:0] bias_code,
  output logic              at_floor,
  output logic              at_ceiling,
  output logic              settled
);
  ctl_state_e       state_q, state_d;
  logic [AMP_W-1:0] samp_q;
  step_e            dir_q, dir_raw;
  logic             boot_q, boot_d;
  logic             win_open;
  logic             cap_en, dec_en, app_en;

  assign win_open = run_cont | quiet_win | boot_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    dec_en  = 1'b0;
    app_en  = 1'b0;
    case (state_q)
      ST_IDLE:   state_d = win_open ? ST_WAIT : ST_HOLD;
      ST_WAIT: begin
        if (!win_open) state_d = ST_HOLD;
        else if (sample_vld) begin
          cap_en  = 1'b1;
          state_d = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        dec_en  = 1'b1;
        state_d = ST_APPLY;
      end
      ST_APPLY: begin
        app_en  = 1'b1;
        state_d = win_open ? ST_WAIT : ST_HOLD;
      end
      ST_HOLD:   if (win_open) state_d = ST_WAIT;
      default:   state_d = ST_IDLE;
    endcase
  end

  // start-up window closes once for good at first settle
  always_comb begin
    boot_d = boot_q;
    if (settled) boot_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      boot_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      boot_q  <= boot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      samp_q <= '0;
    else if (cap_en) samp_q <= sample_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= STEP_NONE;
    else if (dec_en) dir_q <= dir_raw;
  end

  amp_band_cmp #(.AMP_W(AMP_W)) u_cmp (
    .meas      (samp_q),
    .goal      (target_code),
    .half_band (band_lsb),
    .dir       (dir_raw)
  );

  bias_stepper #(.BIAS_W(BIAS_W)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (app_en),
    .dir       (dir_q),
    .bias      (bias_code),
    .floor_hit (at_floor),
    .ceil_hit  (at_ceiling)
  );

  settle_tracker #(.CNT_W(CNT_W)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (app_en),
    .in_band (dir_q == STEP_NONE),
    .need    (settle_len),
    .done    (settled)
  );
endmodule

// File: rtl/xo_amp_regulator_chk.sv
module xo_amp_regulator_chk
  import xo_amp_pkg::*;
#(
  parameter int BIAS_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BIAS_W-1:0] bias_code,
  input logic              at_floor,
  input logic              at_ceiling,
  input logic              settled,
  input ctl_state_e        state,
  input step_e             dir
);
  // R2: down decision applied away from the floor drops exactly one code
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_APPLY && dir == STEP_DN && !at_floor)
      |=> ({1'b0, bias_code} + 1'b1 == {1'b0, $past(bias_code)}));

  // R3: up decision applied below full scale adds exactly one code
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_APPLY && dir == STEP_UP && !at_ceiling)
      |=> ({1'b0, bias_code} == {1'b0, $past(bias_code)} + 1'b1));

  // R4: in-band decision leaves bias alone
  a_r4_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_APPLY && dir == STEP_NONE) |=> $stable(bias_code));

  // R5: any change is a single non-wrapping step
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bias_code) |->
      (({1'b0, bias_code} == {1'b0, $past(bias_code)} + 1'b1) ||
       ({1'b0, bias_code} + 1'b1 == {1'b0, $past(bias_code)})));

  // R5: at the top, an up step keeps the ceiling flag
  a_r5_ceiling_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_APPLY && dir == STEP_UP && at_ceiling) |=> at_ceiling);

  // R6: settled rises only from an applied sample
  a_r6_settle_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> $past(state == ST_APPLY));

  // R8: holding state freezes the bias
  a_r8_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |=> $stable(bias_code));

  // R10: bias moves only right after an apply cycle
  a_r10_change_after_apply: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bias_code) |-> $past(state == ST_APPLY));
endmodule

bind xo_amp_regulator xo_amp_regulator_chk #(.BIAS_W(BIAS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bias_code  (bias_code),
  .at_floor   (at_floor),
  .at_ceiling (at_ceiling),
  .settled    (settled),
  .state      (state_q),
  .dir        (dir_q)
);

// File: tb/tb_xo_amp_regulator.sv
module tb_xo_amp_regulator;
  localparam int AMP_W  = 8;
  localparam int BIAS_W = 6;
  localparam int CNT_W  = 4;
  localparam int FULL   = (1 << BIAS_W) - 1;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              run_cont, quiet_win, sample_vld;
  logic [AMP_W-1:0]  sample_code, target_code, band_lsb;
  logic [CNT_W-1:0]  settle_len;
  logic [BIAS_W-1:0] bias_code;
  logic              at_floor, at_ceiling, settled;

  int n_chk  = 0;
  int n_fail = 0;
  int m_bias, m_cnt;

  always #2 clk = ~clk;   // 250 MHz

  xo_amp_regulator #(.AMP_W(AMP_W), .BIAS_W(BIAS_W), .CNT_W(CNT_W)) dut (
    .clk, .rst_n, .run_cont, .quiet_win, .sample_vld, .sample_code,
    .target_code, .band_lsb, .settle_len, .bias_code, .at_floor,
    .at_ceiling, .settled
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_dir(int s, int t, int b);
    if (s + b < t) return 1;
    if (s > t + b) return -1;
    return 0;
  endfunction

  // reference model update for an acted-on sample
  task automatic model_apply(int s);
    int d;
    d = ref_dir(s, int'(target_code), int'(band_lsb));
    if (d > 0 && m_bias < FULL) m_bias++;
    if (d < 0 && m_bias > 0)    m_bias--;
    if (d == 0) m_cnt = (m_cnt < CMAX) ? m_cnt + 1 : CMAX;
    else        m_cnt = 0;
  endtask

  // one spare edge, strobe for 'len' cycles, then three edges of latency
  task automatic xact(int s, int len);
    sample_code = AMP_W'(s);
    @(negedge clk);
    sample_vld = 1'b1;
    repeat (len) @(negedge clk);
    sample_vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_state(string req);
    check({req, " bias"}, int'(bias_code), m_bias);
    check({req, " settled"}, int'(settled), int'(m_cnt >= int'(settle_len)));
  endtask

  initial begin
    #(4 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0a11;
    void'($urandom(seed));
    rst_n = 1'b0; run_cont = 1'b0; quiet_win = 1'b0; sample_vld = 1'b0;
    sample_code = '0; target_code = 8'd100; band_lsb = 8'd2; settle_len = 4'd3;
    m_bias = FULL; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 bias in reset", int'(bias_code), FULL);
    check("R1 ceiling in reset", int'(at_ceiling), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 bias", int'(bias_code), FULL);
    check("R1 floor", int'(at_floor), 0);
    check("R1 settled", int'(settled), 0);

    // R7 start-up window: acts with run_cont=0, quiet_win=0
    xact(120, 1); model_apply(120); chk_state("R2 R7 far above");
    xact(103, 1); model_apply(103); chk_state("R2 just above band");
    xact(102, 1); model_apply(102); chk_state("R4 top band edge");
    xact(98, 1);  model_apply(98);  chk_state("R4 bottom band edge");
    xact(97, 1);  model_apply(97);  chk_state("R3 just below band");
    xact(100, 1); model_apply(100);
    xact(101, 1); model_apply(101); chk_state("R6 two in band");
    xact(99, 1);  model_apply(99);  chk_state("R6 three in band");
    check("R6 settled rises", int'(settled), 1);

    // R7/R8: start-up window now closed, sample ignored
    xact(120, 1); chk_state("R7 R8 closed window ignored");
    // R8 quiet window open
    quiet_win = 1'b1;
    xact(120, 1); model_apply(120); chk_state("R8 quiet window acts");
    check("R6 cleared by outlier", int'(settled), 0);
    quiet_win = 1'b0;
    xact(30, 1); chk_state("R8 window closed again");

    // R10 double-length strobe, continuous mode
    run_cont = 1'b1;
    xact(120, 2); model_apply(120); chk_state("R10 two-cycle strobe one step");

    // R5 floor
    for (int i = 0; i < FULL; i++) begin xact(255, 1); model_apply(255); end
    check("R5 reaches floor", int'(bias_code), 0);
    check("R5 floor flag", int'(at_floor), 1);
    check("R5 ceiling flag low", int'(at_ceiling), 0);
    xact(255, 1); model_apply(255); check("R5 no wrap below 0", int'(bias_code), 0);
    // R5 ceiling
    for (int i = 0; i < FULL; i++) begin xact(0, 1); model_apply(0); end
    check("R5 reaches ceiling", int'(bias_code), FULL);
    check("R5 ceiling flag", int'(at_ceiling), 1);
    xact(0, 1); model_apply(0); check("R5 no wrap above full", int'(bias_code), FULL);
    check("R5 floor flag low", int'(at_floor), 0);

    // constrained random: R2 R3 R4 R6 R8 R9
    for (int i = 0; i < 400; i++) begin
      int s;
      run_cont    = 1'($urandom % 2);
      quiet_win   = 1'($urandom % 2);
      target_code = AMP_W'(60 + ($urandom % 140));
      band_lsb    = AMP_W'($urandom % 5);
      s = int'(target_code) + int'($urandom % 15) - 7;
      xact(s, 1);
      if (run_cont || quiet_win) model_apply(s);
      chk_state(run_cont ? "R9 random continuous" : "R8 random windowed");
      check("R5 random floor flag", int'(at_floor), int'(m_bias == 0));
      check("R5 random ceiling flag", int'(at_ceiling), int'(m_bias == FULL));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule